// File: doc/BRIEF.md
# Accumulator Result Signature Detector

This block observes every write to the 8-bit accumulator of a small processor core. Test software reports its verdict by writing a fixed three-byte signature: AAh, then 55h, then a code byte. A code of 01h means pass and a code of 00h means fail. The detector recognises that signature and raises a done flag together with exactly one of a pass flag or a fail flag. All three flags then hold until reset, so they can drive status pins or a simulation monitor directly.

The recognizer is a small state machine that runs all the time. It samples the accumulator only on cycles where the write strobe is high. Any byte that breaks the sequence sends the search back to its start. The exception is a breaking byte equal to AAh, which is kept and counts as the first byte of a new attempt. The byte values are parameters, and the defaults give the encodings above.

Top module: `acc_sig_detect`

## Requirements
- R1: While rst_n is low (asynchronous, active low), done_o, pass_o and fail_o are all 0, and the search restarts from its initial state once rst_n is released.
- R2: On a cycle with wr_stb_i low, the value on acc_i has no effect. A signature byte presented without the strobe is not counted.
- R3: Strobed writes AAh, 55h, 01h in consecutive strobed writes set done_o and pass_o on the clock edge that samples 01h, so both are visible in the cycle after that edge. fail_o stays 0.
- R4: Strobed writes AAh, 55h, 00h set done_o and fail_o on the clock edge that samples 00h. pass_o stays 0.
- R5: A strobed byte that does not continue the sequence and is not AAh returns the search to waiting for AAh. For example, AAh, 12h, 55h, 01h gives no result.
- R6: A strobed AAh that breaks the sequence counts as the first signature byte. So AAh, AAh, 55h, 01h gives pass, and AAh, 55h, AAh, 55h, 00h gives fail.
- R7: Repeated strobed writes of the same value count as separate sequence elements. AAh, 55h, 55h, 01h gives no result.
- R8: Once done_o is 1, the values of done_o, pass_o and fail_o do not change on any later write until reset.
- R9: pass_o and fail_o are never 1 together, and both are 0 whenever done_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| wr_stb_i | input | 1 | High on cycles where the accumulator is written |
| acc_i | input | 8 | Accumulator value |
| done_o | output | 1 | A result signature was seen (latched) |
| pass_o | output | 1 | The result code was the pass code (latched) |
| fail_o | output | 1 | The result code was the fail code (latched) |

## Verification
Two of the block's actions can fall on the same edge. A mismatch abandons the current attempt, and when the breaking byte is AAh a new attempt starts on that same edge. This happens when AAh arrives while the block waits for 55h or for the code byte. The directed sequences AAh, AAh, 55h, 01h and AAh, 55h, AAh, 55h, 00h provoke this case, and the random stimulus, weighted toward signature bytes, provokes it often. Each case is judged by comparing the flags every cycle against a bench model in which a mismatching AAh re-arms the search.

// File: rtl/acc_sig_pkg.sv
package acc_sig_pkg;

  typedef enum logic [1:0] {
    ST_SEEK = 2'd0,
    ST_HEAD = 2'd1,
    ST_BODY = 2'd2,
    ST_HELD = 2'd3
  } sig_state_e;

  localparam int unsigned N_CODES  = 4;
  localparam int unsigned M_LEAD   = 0;
  localparam int unsigned M_SECOND = 1;
  localparam int unsigned M_PASS   = 2;
  localparam int unsigned M_FAIL   = 3;

endpackage

// File: rtl/acc_sig_match.sv
module acc_sig_match #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned N        = 4,
  parameter logic [N*DATA_W-1:0] CODE_VEC = '0
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stb_i,
  output logic [N-1:0]      hit_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = stb_i && (byte_i == CODE_VEC[g*DATA_W +: DATA_W]);
  end

endmodule

// File: rtl/acc_sig_fsm.sv
module acc_sig_fsm
  import acc_sig_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stb_i,
  input  logic [N_CODES-1:0] hit_i,
  output logic               pass_ev_o,
  output logic               fail_ev_o
);

  sig_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d   = state_q;
    pass_ev_o = 1'b0;
    fail_ev_o = 1'b0;
    unique case (state_q)
      ST_SEEK: if (hit_i[M_LEAD]) state_d = ST_HEAD;
      ST_HEAD: begin
        if (hit_i[M_SECOND])    state_d = ST_BODY;
        else if (hit_i[M_LEAD]) state_d = ST_HEAD;
        else                    state_d = ST_SEEK;
      end
      ST_BODY: begin
        if (hit_i[M_PASS]) begin
          state_d   = ST_HELD;
          pass_ev_o = 1'b1;
        end else if (hit_i[M_FAIL]) begin
          state_d   = ST_HELD;
          fail_ev_o = 1'b1;
        end else if (hit_i[M_LEAD]) begin
          state_d = ST_HEAD;
        end else begin
          state_d = ST_SEEK;
        end
      end
      default: state_d = ST_HELD;
    endcase
  end

  assign state_en = stb_i && (state_q != ST_HELD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEEK;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/acc_sig_result.sv
module acc_sig_result (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_ev_i,
  input  logic fail_ev_i,
  output logic done_o,
  output logic pass_o,
  output logic fail_o
);

  logic done_q, pass_q, fail_q;
  logic set_en;

  assign set_en = !done_q && (pass_ev_i || fail_ev_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (set_en) begin
      done_q <= 1'b1;
      pass_q <= pass_ev_i;
      fail_q <= fail_ev_i && !pass_ev_i;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;

endmodule

// File: rtl/acc_sig_detect.sv
module acc_sig_detect
  import acc_sig_pkg::*;
#(
  parameter int unsigned        DATA_W    = 8,
  parameter logic [DATA_W-1:0]  LEAD_B    = 8'hAA,
  parameter logic [DATA_W-1:0]  SECOND_B  = 8'h55,
  parameter logic [DATA_W-1:0]  PASS_B    = 8'h01,
  parameter logic [DATA_W-1:0]  FAIL_B    = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);

  localparam logic [N_CODES*DATA_W-1:0] CODES = {FAIL_B, PASS_B, SECOND_B, LEAD_B};

  logic [N_CODES-1:0] hit;
  logic               pass_ev, fail_ev;

  acc_sig_match #(
    .DATA_W  (DATA_W),
    .N       (N_CODES),
    .CODE_VEC(CODES)
  ) u_match (
    .byte_i(acc_i),
    .stb_i (wr_stb_i),
    .hit_o (hit)
  );

  acc_sig_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_i    (wr_stb_i),
    .hit_i    (hit),
    .pass_ev_o(pass_ev),
    .fail_ev_o(fail_ev)
  );

  acc_sig_result u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .pass_ev_i(pass_ev),
    .fail_ev_i(fail_ev),
    .done_o   (done_o),
    .pass_o   (pass_o),
    .fail_o   (fail_o)
  );

endmodule

// File: rtl/acc_sig_detect_chk.sv
module acc_sig_detect_chk #(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] PASS_B = 8'h01,
  parameter logic [DATA_W-1:0] FAIL_B = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb_i,
  input logic [DATA_W-1:0] acc_i,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (!done_o && !pass_o && !fail_o);
    end
  end

  // R2
  no_strobe_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb_i && !done_o) |=> !done_o);

  // R3
  pass_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> ($past(wr_stb_i) && $past(acc_i) == PASS_B));

  // R4
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> ($past(wr_stb_i) && $past(acc_i) == FAIL_B));

  // R8
  latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && $stable(pass_o) && $stable(fail_o)));

  // R9
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o) && (done_o || (!pass_o && !fail_o)));

  // R9
  done_has_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $countones({pass_o, fail_o}) == 1);

endmodule

bind acc_sig_detect acc_sig_detect_chk #(
  .DATA_W(DATA_W),
  .PASS_B(PASS_B),
  .FAIL_B(FAIL_B)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_stb_i(wr_stb_i),
  .acc_i   (acc_i),
  .done_o  (done_o),
  .pass_o  (pass_o),
  .fail_o  (fail_o)
);

// File: tb/acc_sig_detect_tb.sv
module acc_sig_detect_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb_i;
  logic [7:0] acc_i;
  logic       done_o, pass_o, fail_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state: 0 seek, 1 got AA, 2 got 55, 3 held
  int   m_st;
  logic m_done, m_pass, m_fail;

  acc_sig_detect u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb_i(wr_stb_i),
    .acc_i   (acc_i),
    .done_o  (done_o),
    .pass_o  (pass_o),
    .fail_o  (fail_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual cycles %0d expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int model_next(int st, logic s, logic [7:0] a);
    if (!s || st == 3) return st;
    case (st)
      0: return (a == 8'hAA) ? 1 : 0;
      1: return (a == 8'h55) ? 2 : (a == 8'hAA) ? 1 : 0;
      default: return (a == 8'h01 || a == 8'h00) ? 3 : (a == 8'hAA) ? 1 : 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual done/pass/fail=%b expected=%b", tag, got, exp);
    end
  endtask

  // one cycle: check outputs at negedge against model, then drive next input
  task automatic step(string tag, logic s, logic [7:0] a);
    @(negedge clk);
    chk(tag, {done_o, pass_o, fail_o}, {m_done, m_pass, m_fail});
    wr_stb_i = s;
    acc_i    = a;
    if (s && m_st == 2 && a == 8'h01) begin m_done = 1; m_pass = 1; end
    if (s && m_st == 2 && a == 8'h00) begin m_done = 1; m_fail = 1; end
    m_st = model_next(m_st, s, a);
  endtask

  task automatic expect_now(string tag, logic [2:0] exp);
    step(tag, 1'b0, 8'h00);
    chk(tag, {done_o, pass_o, fail_o}, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_stb_i = 1'b0;
    acc_i = 8'h00;
    m_st = 0; m_done = 0; m_pass = 0; m_fail = 0;
    @(negedge clk);
    chk("R1", {done_o, pass_o, fail_o}, 3'b000);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    wr_stb_i = 1'b0;
    acc_i = 8'h00;
    m_st = 0; m_done = 0; m_pass = 0; m_fail = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1", {done_o, pass_o, fail_o}, 3'b000);
    rst_n = 1'b1;

    // R3 basic pass
    step("R3", 1, 8'hAA); step("R3", 1, 8'h55); step("R3", 1, 8'h01);
    expect_now("R3", 3'b110);
    // R8 latched after further writes
    step("R8", 1, 8'hAA); step("R8", 1, 8'h55); step("R8", 1, 8'h00);
    expect_now("R8", 3'b110);

    // R4 basic fail, with idle gaps between writes
    do_reset();
    step("R4", 1, 8'hAA); step("R4", 0, 8'h13); step("R4", 1, 8'h55);
    step("R4", 1, 8'h00);
    expect_now("R4", 3'b101);

    // R2 signature bytes without strobe ignored
    do_reset();
    step("R2", 0, 8'hAA); step("R2", 0, 8'h55); step("R2", 0, 8'h01);
    expect_now("R2", 3'b000);
    step("R2", 1, 8'hAA); step("R2", 0, 8'h77); step("R2", 1, 8'h55);
    step("R2", 0, 8'hAA); step("R2", 1, 8'h01);
    expect_now("R2", 3'b110);

    // R5 non-AA mismatch restarts
    do_reset();
    step("R5", 1, 8'hAA); step("R5", 1, 8'h12); step("R5", 1, 8'h55);
    step("R5", 1, 8'h01);
    expect_now("R5", 3'b000);
    step("R5", 1, 8'hAA); step("R5", 1, 8'h55); step("R5", 1, 8'h7F);
    step("R5", 1, 8'h01);
    expect_now("R5", 3'b000);

    // R6 mismatching AA re-arms
    do_reset();
    step("R6", 1, 8'hAA); step("R6", 1, 8'hAA); step("R6", 1, 8'h55);
    step("R6", 1, 8'h01);
    expect_now("R6", 3'b110);
    do_reset();
    step("R6", 1, 8'hAA); step("R6", 1, 8'h55); step("R6", 1, 8'hAA);
    step("R6", 1, 8'h55); step("R6", 1, 8'h00);
    expect_now("R6", 3'b101);

    // R7 repeated value is a separate element
    do_reset();
    step("R7", 1, 8'hAA); step("R7", 1, 8'h55); step("R7", 1, 8'h55);
    step("R7", 1, 8'h01);
    expect_now("R7", 3'b000);

    // R1 reset mid-sequence clears progress
    do_reset();
    step("R1", 1, 8'hAA); step("R1", 1, 8'h55);
    do_reset();
    step("R1", 1, 8'h01);
    expect_now("R1", 3'b000);

    // R9 random stimulus against model, periodic resets
    do_reset();
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] b;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0, 1: b = 8'hAA;
        2:    b = 8'h55;
        3:    b = 8'h01;
        4:    b = 8'h00;
        default: b = 8'($urandom);
      endcase
      step("R9", ($urandom_range(0, 3) != 0), b);
      if ((pass_o && fail_o) || (!done_o && (pass_o || fail_o))) begin
        errors++;
        $display("FAIL R9: actual done/pass/fail=%b%b%b expected exclusive verdict",
                 done_o, pass_o, fail_o);
      end
      if (i % 97 == 96) do_reset();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule